// File: doc/BRIEF.md
# Cascadable Presettable Up/Down Counter

A synchronous binary counter whose bits are built as toggle stages. On each rising clock edge the count steps up or down by one, depending on a direction input. This happens only while the carry-in enable is high. A parallel load replaces the count with an external value, and a synchronous reset clears it.

A single carry/borrow output reports that the next enabled step will wrap. In up mode that is the step from all ones to zero; in down mode it is the step from zero to all ones. Because this output is combinational, it can drive the carry-in of the next unit. Chained units then form a wider counter in which every unit changes on the same edge.

Top module: `udc_counter`

## Requirements
- R1: With rst=0, load_en=0, cin=1 and dir_up=1, the count after a rising edge is the previous count plus one, modulo 2^WIDTH (WIDTH=4 by default).
- R2: With rst=0, load_en=0, cin=1 and dir_up=0, the count after a rising edge is the previous count minus one, modulo 2^WIDTH.
- R3: With rst=0 and load_en=1, the count after a rising edge equals load_val, whatever the values of cin and dir_up.
- R4: With rst=1, the count after a rising edge is zero, even when load_en=1. Reset acts only at the clock edge.
- R5: With rst=0, load_en=0 and cin=0, the count keeps its value across a rising edge, in either direction.
- R6: cout is 1 exactly when cin=1 and either dir_up=1 with every count bit 1, or dir_up=0 with every count bit 0. It follows its inputs in the same cycle, with no register between them.
- R7: Two units chained, with the low unit's cout feeding the high unit's cin and rst, load_en and dir_up shared, behave as one 8-bit counter with the same rules. The high unit moves on the very edge at which the low unit wraps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high clear, highest priority |
| dir_up | input | 1 | 1 counts up, 0 counts down |
| load_en | input | 1 | Parallel load enable, priority over counting |
| load_val | input | WIDTH | Value loaded when load_en is high |
| cin | input | 1 | Count enable / carry-in from a lower unit |
| count | output | WIDTH | Current count |
| cout | output | 1 | Carry (up) or borrow (down) toward a higher unit |

## Verification
The bench targets the two wrap points, 15 to 0 going up and 0 to 15 going down. A design with a broken toggle product for an upper bit would skip or repeat a value there. A design that decodes the wrong terminal pattern for the current direction would raise cout at the wrong count.

The bench also drives cin low while the count sits at a terminal value. A cout that ignores cin would then advance the upper unit of the chain. Load and reset are asserted together and against an active cin, which exposes a reversed priority. The chained pair is checked against an 8-bit model, so a registered cout would show up as a one-cycle lag in the high nibble.

// File: rtl/udc_pkg.sv
package udc_pkg;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } dir_e;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_STEP  = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } op_e;

    typedef struct packed {
        op_e  op;
        dir_e dir;
    } ctrl_t;

    // Priority: clear over load over step over hold
    function automatic op_e pick_op(input logic rst, input logic load, input logic en);
        if (rst)       return OP_CLEAR;
        else if (load) return OP_LOAD;
        else if (en)   return OP_STEP;
        else           return OP_HOLD;
    endfunction

endpackage

// File: rtl/udc_term_chain.sv
module udc_term_chain
    import udc_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] q,
    input  dir_e             dir,
    input  logic             cin,
    output logic [WIDTH-1:0] toggle,
    output logic             term
);
    // Running products of the lower bits: all ones / all zeros below bit i
    logic [WIDTH:0] ones_below;
    logic [WIDTH:0] zeros_below;

    assign ones_below[0]  = 1'b1;
    assign zeros_below[0] = 1'b1;

    for (genvar i = 0; i < WIDTH; i++) begin : g_chain
        assign ones_below[i+1]  = ones_below[i]  & q[i];
        assign zeros_below[i+1] = zeros_below[i] & ~q[i];
        assign toggle[i] = cin & ((dir == DIR_UP) ? ones_below[i] : zeros_below[i]);
    end

    assign term = cin & ((dir == DIR_UP) ? ones_below[WIDTH] : zeros_below[WIDTH]);

endmodule

// File: rtl/udc_tstage.sv
module udc_tstage
    import udc_pkg::*;
(
    input  logic clk,
    input  op_e  op,
    input  logic tgl,
    input  logic ld_bit,
    output logic q
);
    always_ff @(posedge clk) begin
        case (op)
            OP_CLEAR: q <= 1'b0;
            OP_LOAD:  q <= ld_bit;
            OP_STEP:  q <= q ^ tgl;
            default:  q <= q;
        endcase
    end

endmodule

// File: rtl/udc_counter.sv
module udc_counter
    import udc_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dir_up,
    input  logic             load_en,
    input  logic [WIDTH-1:0] load_val,
    input  logic             cin,
    output logic [WIDTH-1:0] count,
    output logic             cout
);
    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] ONE      = WIDTH'(1);

    ctrl_t            ctrl;
    logic [WIDTH-1:0] toggle;

    assign ctrl.op  = pick_op(rst, load_en, cin);
    assign ctrl.dir = dir_e'(dir_up);

    udc_term_chain #(.WIDTH(WIDTH)) i_chain (
        .q      (count),
        .dir    (ctrl.dir),
        .cin    (cin),
        .toggle (toggle),
        .term   (cout)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        udc_tstage i_stage (
            .clk    (clk),
            .op     (ctrl.op),
            .tgl    (toggle[i]),
            .ld_bit (load_val[i]),
            .q      (count[i])
        );
    end

    // R1: up step
    a_r1_up_step: assert property (@(posedge clk) disable iff (rst)
        (!load_en && cin && dir_up) |=> (count == $past(count) + ONE));

    // R2: down step
    a_r2_down_step: assert property (@(posedge clk) disable iff (rst)
        (!load_en && cin && !dir_up) |=> (count == $past(count) - ONE));

    // R3: load wins over counting
    a_r3_load: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (count == $past(load_val)));

    // R4: synchronous clear with top priority
    a_r4_clear: assert property (@(posedge clk)
        rst |=> (count == '0));

    // R5: hold when not enabled
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        (!load_en && !cin) |=> $stable(count));

    // R6: carry/borrow predicts a wrap on the next enabled step
    a_r6_wrap_up: assert property (@(posedge clk) disable iff (rst)
        (cout && dir_up && !load_en) |=> (count == '0));

    a_r6_wrap_down: assert property (@(posedge clk) disable iff (rst)
        (cout && !dir_up && !load_en) |=> (count == ALL_ONES));

    a_r6_needs_cin: assert property (@(posedge clk) disable iff (rst)
        !cin |-> !cout);

endmodule

// File: tb/test_udc_counter.sv
module test_udc_counter;

    logic       clk = 1'b0;
    logic       rst, dir_up, load_en, cin;
    logic [3:0] load_val;
    logic [3:0] count;
    logic       cout;

    // chained pair
    logic [7:0] c_load;
    logic       c_cin;
    logic [3:0] lo_cnt, hi_cnt;
    logic       lo_cout, hi_cout;

    int checks = 0;
    int errors = 0;
    int unsigned m1;
    int unsigned m8;
    bit done = 0;

    always #2 clk = ~clk;

    udc_counter #(.WIDTH(4)) i_udc_counter (
        .clk(clk), .rst(rst), .dir_up(dir_up), .load_en(load_en),
        .load_val(load_val), .cin(cin), .count(count), .cout(cout));

    udc_counter #(.WIDTH(4)) i_lo (
        .clk(clk), .rst(rst), .dir_up(dir_up), .load_en(load_en),
        .load_val(c_load[3:0]), .cin(c_cin), .count(lo_cnt), .cout(lo_cout));

    udc_counter #(.WIDTH(4)) i_hi (
        .clk(clk), .rst(rst), .dir_up(dir_up), .load_en(load_en),
        .load_val(c_load[7:4]), .cin(lo_cout), .count(hi_cnt), .cout(hi_cout));

    function automatic int unsigned next_val(input int unsigned cur, input int unsigned modv,
                                             input bit r, input bit ld, input int unsigned lv,
                                             input bit en, input bit up);
        if (r)       return 0;
        else if (ld) return lv;
        else if (en) return up ? (cur + 1) % modv : (cur + modv - 1) % modv;
        else         return cur;
    endfunction

    function automatic bit exp_cout(input int unsigned cur, input int unsigned modv,
                                    input bit en, input bit up);
        return en && (up ? (cur == modv - 1) : (cur == 0));
    endfunction

    task automatic check(input string req, input int unsigned act, input int unsigned exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive at negedge, check carries, clock, check counts
    task automatic cycle(input bit r, input bit up, input bit ld, input logic [3:0] lv,
                         input bit en, input logic [7:0] clv, input bit cen, input string req);
        @(negedge clk);
        rst = r; dir_up = up; load_en = ld; load_val = lv; cin = en;
        c_load = clv; c_cin = cen;
        #1;
        check("R6 cout", cout, exp_cout(m1, 16, en, up));
        check("R7 chain cout", hi_cout, exp_cout(m8, 256, cen, up));
        m1 = next_val(m1, 16, r, ld, lv, en, up);
        m8 = next_val(m8, 256, r, ld, clv, cen, up);
        @(posedge clk);
        #1;
        check(req, count, m1);
        check("R7 chain", {hi_cnt, lo_cnt}, m8);
    endtask

    initial begin
        #(4 * 20000);
        $display("FAIL watchdog: actual=timeout expected=finish");
        errors++;
        checks++;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1; dir_up = 1; load_en = 0; load_val = 0; cin = 0; c_load = 0; c_cin = 0;
        m1 = 0; m8 = 0;
        void'($urandom(32'd1234));
        cycle(1, 1, 0, 4'd0, 0, 8'd0, 0, "R4 reset");
        // R4: reset beats load
        cycle(1, 1, 1, 4'd9, 1, 8'h5A, 1, "R4 reset over load");
        // R1 up run through wrap (R6 at 15)
        for (int i = 0; i < 18; i++) cycle(0, 1, 0, 4'd0, 1, 8'd0, 1, "R1 up");
        // R3 load to 15 then hold at terminal with cin=0 (R5, cout must stay 0)
        cycle(0, 1, 1, 4'd15, 0, 8'h0F, 0, "R3 load");
        cycle(0, 1, 0, 4'd0, 0, 8'd0, 0, "R5 hold at terminal");
        cycle(0, 1, 0, 4'd0, 1, 8'd0, 1, "R1 wrap 15->0");
        // R2 down through 0 -> 15
        for (int i = 0; i < 18; i++) cycle(0, 0, 0, 4'd0, 1, 8'd0, 1, "R2 down");
        // R3 load beats active count
        cycle(0, 0, 1, 4'd0, 1, 8'h00, 1, "R3 load over cin");
        cycle(0, 0, 0, 4'd0, 1, 8'd0, 1, "R2 wrap 0->15");
        cycle(0, 0, 0, 4'd0, 0, 8'd0, 0, "R5 hold down");
        // Random mix
        for (int i = 0; i < 600; i++) begin
            int unsigned rv;
            rv = $urandom;
            cycle((rv % 50) == 0, rv[8], (rv % 13) == 0, 4'($urandom),
                  (rv % 5) != 0, 8'($urandom), (rv % 4) != 0, "R1/R2/R3/R5 random");
        end
        // Long chained up run across a nibble boundary
        cycle(0, 1, 1, 4'd14, 1, 8'h0E, 1, "R3 load");
        for (int i = 0; i < 40; i++) cycle(0, 1, 0, 4'd0, 1, 8'd0, 1, "R1 chain up");
        for (int i = 0; i < 40; i++) cycle(0, 0, 0, 4'd0, 1, 8'd0, 1, "R2 chain down");
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule